// File: doc/BRIEF.md
# Disk Controller Register Front End with Sector Buffer

This block is the host-facing register file of a simplified floppy disk controller. A processor reaches four byte-wide registers through a small bus: command on write and status on read, track, sector, and a data port. Behind the data port is a byte buffer with a read position and a fill length. A side load port appends bytes to the buffer, standing in for sector data arriving from the media. The host or a DMA engine drains the buffer through the data port, or fills it for a write command.

Two status bits are computed live from the buffer pointers rather than stored. Busy and data-request both follow "bytes remain". The interrupt does not come from a completion timer. It is raised when the last buffered byte passes through the data port, and also when a positioning or force-interrupt command is issued. An interrupt latch drives the interrupt pin, which a host would typically wire to processor interrupt level 2. A companion edge flag marks that the latch rose from clear.

Top module: `disk_reg_frontend`

## Requirements
- R1: After reset both buffer pointers, the stored status and both interrupt flags are zero. A status read then returns 0x00, and a data read returns 0xFF.
- R2: Address bits 2:1 select the register: 0 is command/status, 1 is track, 2 is sector, 3 is data. Address bit 0 is ignored. The track and sector registers read back the last value written.
- R3: In data-request mode, which is entered by any command with bit 7 set except the 0xF_ code, status bits 1 and 0 both read as 1 exactly when read position is below length. The upper bits come from the stored status.
- R4: In positioning mode, entered by a command with bit 7 clear, status bit 0 reads as 1 exactly when read position is below length, and bit 1 shows the stored value unchanged.
- R5: A status read clears both the interrupt latch and the edge flag on that clock edge.
- R6: A data read returns the byte at the read position and advances the position. When the buffer is empty it returns 0xFF and the position does not move.
- R7: A data write stores the byte and advances the position only while position is below length. Otherwise it does not change the buffer pointers.
- R8: A data read or write that moves the last buffered byte sets the interrupt latch. The edge flag is set if the latch was clear before, and otherwise keeps its value.
- R9: With no media present, a command whose upper nibble is 0x8, 0x9, 0xA, 0xB, 0xC, 0xD or 0xE sets the stored status to 0x80 and changes nothing else.
- R10: With media present, read commands (upper nibble 0x8, 0x9, 0xC, 0xE) clear the status and empty the buffer. Write commands (0xA, 0xB) clear the status and set position 0 and length WR_LEN.
- R11: With media present, the force-interrupt command (upper nibble 0xD) clears the status, empties the buffer and raises the interrupt.
- R12: Any command write first clears the interrupt latch. The 0xF_ code does nothing else.
- R13: The load port writes its byte at the current length and increments the length. It is ignored when length equals BUF_DEPTH.
- R14: A positioning command raises the interrupt. Code 0x0_ sets track to 0, code 0x1_ copies the last data-port write into track, and other codes keep track. The stored status becomes {no-media, 0000, track-is-zero, index input, 0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access strobe, one access per cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register address; bits 2:1 decode |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register (combinational) |
| loadValid | input | 1 | Append loadByte to the buffer |
| loadByte | input | 8 | Byte from media side |
| mediaPresent | input | 1 | 1 = disk inserted |
| indexPulse | input | 1 | Index sensor level, captured by positioning commands |
| irqOut | output | 1 | Interrupt latch |
| irqEdge | output | 1 | Edge flag: latch rose from clear |

## Verification
The status byte is read after every kind of command and buffer state: empty, partly filled, and drained. This tells the data-request rule, which mirrors "bytes remain" onto two bits, apart from the positioning rule, which passes bit 1 through. A seek taken with the index input high and an empty buffer yields 0x02, which only the pass-through rule gives. The interrupt flags are checked after a first last-byte transfer, after a repeated one, after a command that only clears, and after a status read; this separates the latch from the edge flag. Filling the buffer past its depth, and writing past the armed length, show that surplus traffic leaves the pointers alone.

// File: rtl/dskfe_pkg.sv
package dskfe_pkg;

  typedef enum logic [1:0] {
    REG_CMD    = 2'd0,
    REG_TRACK  = 2'd1,
    REG_SECTOR = 2'd2,
    REG_DATA   = 2'd3
  } dskfe_reg_e;

  // Strobes from the control side to the buffer datapath.
  typedef struct packed {
    logic dataRd;    // data port read
    logic dataWr;    // data port write
    logic clrBuf;    // empty the buffer
    logic armWrite;  // position 0, length WR_LEN
  } dskfe_strb_t;

  localparam logic [7:0] STAT_NOT_READY = 8'h80;
  localparam logic [7:0] EMPTY_BYTE     = 8'hFF;

endpackage

// File: rtl/dskfe_buffer.sv
module dskfe_buffer
  import dskfe_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int WR_LEN    = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  dskfe_strb_t strb,
  input  logic [7:0]  wrByte,
  input  logic        loadValid,
  input  logic [7:0]  loadByte,
  output logic [7:0]  headByte,
  output logic        notEmpty,
  output logic        lastByte
);

  localparam int AW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
  localparam int PW = $clog2(BUF_DEPTH + 1);
  localparam logic [PW-1:0] DEPTH_P = PW'(BUF_DEPTH);
  localparam logic [PW-1:0] WRLEN_P = PW'(WR_LEN);

  logic [7:0]    mem [BUF_DEPTH];
  logic [PW-1:0] rdPos;
  logic [PW-1:0] bufLen;
  logic          moveByte;
  logic          loadOk;

  assign notEmpty = rdPos < bufLen;
  assign lastByte = notEmpty && ((rdPos + PW'(1)) == bufLen);
  assign headByte = notEmpty ? mem[rdPos[AW-1:0]] : EMPTY_BYTE;
  assign moveByte = (strb.dataRd || strb.dataWr) && notEmpty;
  assign loadOk   = loadValid && (bufLen < DEPTH_P) && !strb.clrBuf && !strb.armWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPos  <= '0;
      bufLen <= '0;
    end else if (strb.clrBuf) begin
      rdPos  <= '0;
      bufLen <= '0;
    end else if (strb.armWrite) begin
      rdPos  <= '0;
      bufLen <= WRLEN_P;
    end else begin
      if (moveByte) rdPos  <= rdPos + PW'(1);
      if (loadOk)   bufLen <= bufLen + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (strb.dataWr && notEmpty) mem[rdPos[AW-1:0]] <= wrByte;
    if (loadOk)                  mem[bufLen[AW-1:0]] <= loadByte;
  end

  // R7: the position never runs past the length
  p_pos_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    rdPos <= bufLen);

  // R6: a data read of an empty buffer leaves the position alone
  p_empty_read_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && !notEmpty && !strb.clrBuf && !strb.armWrite) |=> $stable(rdPos));

  // R13: a load into a full buffer does not grow it
  p_full_load_r13: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && bufLen == DEPTH_P && !strb.clrBuf && !strb.armWrite) |=> $stable(bufLen));

endmodule

// File: rtl/dskfe_ctrl.sv
module dskfe_ctrl
  import dskfe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic [7:0]  busWdata,
  output logic [7:0]  busRdata,
  input  logic        mediaPresent,
  input  logic        indexPulse,
  input  logic [7:0]  headByte,
  input  logic        notEmpty,
  input  logic        lastByte,
  output dskfe_strb_t strb,
  output logic        irqOut,
  output logic        irqEdge
);

  dskfe_reg_e regSel;
  logic       rdStb, wrStb, cmdWr, statRd;
  logic [3:0] cmdHi;
  logic       isPos, isForce, isRead, isWrite, isFormat;
  logic       raiseCmd, raiseXfer;
  logic [7:0] statusReg, trackReg, sectorReg, dataReg;
  logic       hasDrq, irqLatch;
  logic [7:0] statusView, newTrack;

  assign regSel = dskfe_reg_e'(busAddr[2:1]);
  assign rdStb  = busSel && !busWr;
  assign wrStb  = busSel && busWr;
  assign cmdWr  = wrStb && (regSel == REG_CMD);
  assign statRd = rdStb && (regSel == REG_CMD);
  assign cmdHi  = busWdata[7:4];

  assign isPos    = !busWdata[7];
  assign isForce  = cmdHi == 4'hD;
  assign isFormat = cmdHi == 4'hF;
  assign isWrite  = (cmdHi == 4'hA) || (cmdHi == 4'hB);
  assign isRead   = (cmdHi == 4'h8) || (cmdHi == 4'h9) || (cmdHi == 4'hC) || (cmdHi == 4'hE);

  always_comb begin
    strb          = '0;
    strb.dataRd   = rdStb && (regSel == REG_DATA);
    strb.dataWr   = wrStb && (regSel == REG_DATA);
    strb.clrBuf   = cmdWr && mediaPresent && (isRead || isForce);
    strb.armWrite = cmdWr && mediaPresent && isWrite;
  end

  assign raiseCmd  = cmdWr && (isPos || (isForce && mediaPresent));
  assign raiseXfer = (strb.dataRd || strb.dataWr) && lastByte;

  always_comb begin
    unique case (cmdHi)
      4'h0:    newTrack = 8'h00;
      4'h1:    newTrack = dataReg;
      default: newTrack = trackReg;
    endcase
  end

  // Registers and stored status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      hasDrq    <= 1'b0;
      trackReg  <= '0;
      sectorReg <= '0;
      dataReg   <= '0;
    end else if (wrStb) begin
      unique case (regSel)
        REG_TRACK:  trackReg  <= busWdata;
        REG_SECTOR: sectorReg <= busWdata;
        REG_DATA:   dataReg   <= busWdata;
        REG_CMD: begin
          if (isPos) begin
            trackReg  <= newTrack;
            hasDrq    <= 1'b0;
            statusReg <= {!mediaPresent, 4'b0000, newTrack == 8'h00, indexPulse, 1'b0};
          end else if (!isFormat) begin
            hasDrq    <= 1'b1;
            statusReg <= mediaPresent ? 8'h00 : STAT_NOT_READY;
          end
        end
        default: ;
      endcase
    end
  end

  // Interrupt latch and edge flag
  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqLatch <= 1'b0;
      irqEdge  <= 1'b0;
    end else if (statRd) begin
      irqLatch <= 1'b0;
      irqEdge  <= 1'b0;
    end else if (cmdWr) begin
      irqLatch <= raiseCmd;
      if (raiseCmd) irqEdge <= 1'b1;
    end else if (raiseXfer) begin
      if (!irqLatch) irqEdge <= 1'b1;
      irqLatch <= 1'b1;
    end
  end

  assign irqOut = irqLatch;

  always_comb begin
    if (hasDrq) statusView = {statusReg[7:2], notEmpty, notEmpty};
    else        statusView = {statusReg[7:1], notEmpty};
  end

  always_comb begin
    unique case (regSel)
      REG_CMD:    busRdata = statusView;
      REG_TRACK:  busRdata = trackReg;
      REG_SECTOR: busRdata = sectorReg;
      REG_DATA:   busRdata = headByte;
      default:    busRdata = EMPTY_BYTE;
    endcase
  end

  // R5: a status read leaves both interrupt flags clear
  p_stat_clears_irq_r5: assert property (@(posedge clk) disable iff (!rstN)
    statRd |=> (!irqOut && !irqEdge));

  // R8: the edge flag only rises together with a rise of the latch
  p_edge_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqEdge) |-> (irqLatch && !$past(irqLatch)));

  // R9: a data-class command without media reports not-ready
  p_no_media_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && busWdata[7] && !isFormat && !mediaPresent) |=> (statusReg == STAT_NOT_READY));

  // R12: a command that raises nothing leaves the latch clear
  p_cmd_clears_irq_r12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !raiseCmd) |=> !irqOut);

endmodule

// File: rtl/disk_reg_frontend.sv
module disk_reg_frontend
  import dskfe_pkg::*;
#(
  parameter int BUF_DEPTH = 32,
  parameter int WR_LEN    = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       loadValid,
  input  logic [7:0] loadByte,
  input  logic       mediaPresent,
  input  logic       indexPulse,
  output logic       irqOut,
  output logic       irqEdge
);

  dskfe_strb_t strb;
  logic [7:0]  headByte;
  logic        notEmpty;
  logic        lastByte;

  dskfe_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .busSel       (busSel),
    .busWr        (busWr),
    .busAddr      (busAddr),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .mediaPresent (mediaPresent),
    .indexPulse   (indexPulse),
    .headByte     (headByte),
    .notEmpty     (notEmpty),
    .lastByte     (lastByte),
    .strb         (strb),
    .irqOut       (irqOut),
    .irqEdge      (irqEdge)
  );

  dskfe_buffer #(
    .BUF_DEPTH (BUF_DEPTH),
    .WR_LEN    (WR_LEN)
  ) buf_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrByte    (busWdata),
    .loadValid (loadValid),
    .loadByte  (loadByte),
    .headByte  (headByte),
    .notEmpty  (notEmpty),
    .lastByte  (lastByte)
  );

endmodule

// File: tb/disk_reg_frontend_tb_top.sv
module disk_reg_frontend_tb_top;

  localparam int DEPTH = 32;
  localparam int WRL   = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0, busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       loadValid = 1'b0;
  logic [7:0] loadByte = '0;
  logic       mediaPresent = 1'b1, indexPulse = 1'b0;
  logic       irqOut, irqEdge;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  disk_reg_frontend #(.BUF_DEPTH(DEPTH), .WR_LEN(WRL)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .loadValid(loadValid), .loadByte(loadByte),
    .mediaPresent(mediaPresent), .indexPulse(indexPulse), .irqOut(irqOut), .irqEdge(irqEdge));

  // Addresses: bits 2:1 select the register
  localparam logic [2:0] A_CMD = 3'd0, A_TRK = 3'd2, A_SEC = 3'd4, A_DAT = 3'd6;
  // Ops: 0 write, 1 read and compare, 2 load byte
  // Vector: {op[20:19], addr[18:16], wdata[15:8], expect[7:0]}
  localparam logic [20:0] VEC [16] = '{
    {2'd0, A_TRK, 8'h27, 8'h00},  // R2
    {2'd0, A_SEC, 8'h05, 8'h00},  // R2
    {2'd1, A_TRK, 8'h00, 8'h27},  // R2
    {2'd1, A_SEC, 8'h00, 8'h05},  // R2
    {2'd0, A_CMD, 8'h80, 8'h00},  // R10 read sector
    {2'd1, A_CMD, 8'h00, 8'h00},  // R3 empty
    {2'd2, A_CMD, 8'hA1, 8'h00},  // R13
    {2'd2, A_CMD, 8'hB2, 8'h00},
    {2'd2, A_CMD, 8'hC3, 8'h00},
    {2'd1, A_CMD, 8'h00, 8'h03},  // R3 bytes remain
    {2'd1, A_DAT, 8'h00, 8'hA1},  // R6
    {2'd1, A_DAT, 8'h00, 8'hB2},  // R6
    {2'd1, A_CMD, 8'h00, 8'h03},  // R3 still one left
    {2'd1, A_DAT, 8'h00, 8'hC3},  // R6 last byte
    {2'd1, A_DAT, 8'h00, 8'hFF},  // R6 empty
    {2'd1, A_CMD, 8'h00, 8'h00}   // R3 drained
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busOp(input bit wr, input logic [2:0] addr, input logic [7:0] wd,
                       output logic [7:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = addr; busWdata = wd;
    #1 rd = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] addr, input logic [7:0] wd);
    logic [7:0] dummy;
    busOp(1'b1, addr, wd, dummy);
  endtask

  task automatic rdChk(input string req, input logic [2:0] addr, input logic [7:0] exp);
    logic [7:0] got;
    busOp(1'b0, addr, 8'h00, got);
    check(req, got, exp);
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    loadValid = 1'b1; loadByte = b;
    @(posedge clk);
    #1 loadValid = 1'b0;
  endtask

  task automatic flags(input string req, input logic l, input logic e);
    check({req, " irq"}, {7'd0, irqOut}, {7'd0, l});
    check({req, " edge"}, {7'd0, irqEdge}, {7'd0, e});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    flags("R1", 1'b0, 1'b0);
    rdChk("R1 status", A_CMD, 8'h00);
    rdChk("R1 data", A_DAT, 8'hFF);

    for (int i = 0; i < 16; i++) begin
      logic [20:0] v;
      v = VEC[i];
      case (v[20:19])
        2'd0: wr(v[18:16], v[15:8]);
        2'd1: rdChk($sformatf("R%0d vec%0d", (v[18:16] == A_CMD) ? 3 : ((v[18:16] == A_DAT) ? 6 : 2), i),
                    v[18:16], v[7:0]);
        default: load(v[15:8]);
      endcase
    end

    // R8: first last-byte transfer raises latch and edge
    load(8'h5A);
    rdChk("R6", A_DAT, 8'h5A);
    flags("R8 first", 1'b1, 1'b1);
    load(8'h6B);
    rdChk("R6", A_DAT, 8'h6B);
    flags("R8 repeat", 1'b1, 1'b1);
    // R12: format code only clears the latch
    wr(A_CMD, 8'hF0);
    flags("R12", 1'b0, 1'b1);
    rdChk("R12 status kept", A_CMD, 8'h00);
    flags("R5", 1'b0, 1'b0);

    // R11 force interrupt
    load(8'h11); load(8'h22);
    rdChk("R11 pre", A_CMD, 8'h03);
    wr(A_CMD, 8'hD0);
    flags("R11", 1'b1, 1'b1);
    rdChk("R11 status", A_CMD, 8'h00);
    rdChk("R11 emptied", A_DAT, 8'hFF);

    // R9 no media
    mediaPresent = 1'b0;
    load(8'h33);
    wr(A_CMD, 8'h80);
    rdChk("R9", A_CMD, 8'h83);
    rdChk("R9 buffer kept", A_DAT, 8'h33);
    mediaPresent = 1'b1;

    // R14 / R4 positioning
    indexPulse = 1'b1;
    wr(A_CMD, 8'h00);
    flags("R14", 1'b1, 1'b1);
    rdChk("R14 track", A_TRK, 8'h00);
    rdChk("R14 status", A_CMD, 8'h06);
    wr(A_DAT, 8'h15);
    wr(A_CMD, 8'h10);
    rdChk("R14 seek", A_TRK, 8'h15);
    rdChk("R4 empty", A_CMD, 8'h02);
    indexPulse = 1'b0;
    load(8'h44);
    rdChk("R4 bytes", A_CMD, 8'h03);

    // R10 / R7 write command
    wr(A_CMD, 8'hA0);
    rdChk("R10 write armed", A_CMD, 8'h03);
    for (int i = 0; i < WRL - 1; i++) wr(A_DAT, 8'(i));
    flags("R7 mid", 1'b0, 1'b0);
    rdChk("R7 mid status", A_CMD, 8'h03);
    wr(A_DAT, 8'hEE);
    flags("R8 write", 1'b1, 1'b1);
    rdChk("R7 done", A_CMD, 8'h00);
    wr(A_DAT, 8'h99);
    flags("R7 surplus", 1'b0, 1'b0);
    rdChk("R7 surplus status", A_CMD, 8'h00);

    // R13 full buffer
    wr(A_CMD, 8'h90);
    for (int i = 0; i <= DEPTH; i++) load(8'(i + 16));
    for (int i = 0; i < DEPTH; i++) rdChk("R13", A_DAT, 8'(i + 16));
    rdChk("R13 overflow dropped", A_DAT, 8'hFF);

    // R2 address bit 0 ignored
    wr(3'd3, 8'h3C);
    rdChk("R2 alias", A_TRK, 8'h3C);
    rdChk("R2 alias", 3'd5, 8'h05);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule